// File: doc/BRIEF.md
# Digital Phase-Lock Indicator with Hysteresis

This block decides whether a phase-locked loop has settled. It watches the up and down correction pulses of a phase-frequency detector and flags every clock on which both are high at once. In a settled loop that overlap lasts only a short moment in each reference period. In a loop that has not settled, the overlap width sweeps back and forth at the difference frequency of the two divided inputs.

The block replaces the usual resistor-capacitor integrator and threshold comparator with a saturating up/down counter. Every clock with the overlap pulls the count down by a programmable step. Every other clock raises it by one. The indicator is set when the count climbs to an upper threshold and cleared when it falls to a lower threshold. The band between the two thresholds gives hysteresis, so a short chance overlap during acquisition cannot flip the indicator.

Because the down step is larger than the up step, losing lock is reported several times faster than lock is declared. Two outputs are provided: an active-high flag and an active-low copy for an external indicator. An optional synchroniser stage can be placed on the pulse inputs.

Top module: `pfd_lock_monitor`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, the flag reads 0 and the active-low output reads 1. The internal count starts at 0.
- R2: On each clock edge where up and down are both 1, the count falls by the effective step. It stops at 0 and never wraps below 0.
- R3: On each clock edge where up and down are not both 1, the count rises by one. It saturates at 2^CNT_W-1 and never wraps to 0.
- R4: The step field selects the effective down step. A field value of 0 selects the default of 3; any other value 1..7 is used as the step itself.
- R5: The flag becomes 1 at the same edge where the newly computed count is greater than or equal to the upper threshold.
- R6: The flag becomes 0 at the edge where the new count is less than or equal to the lower threshold. Strictly between the two thresholds, the flag keeps its value.
- R7: If the new count meets both the set and the clear condition, which can happen when the lower threshold is at or above the upper threshold, the set wins and the flag is 1.
- R8: The active-low output is always the complement of the flag.
- R9: An up pulse alone, or a down pulse alone, counts as no coincidence and raises the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pfd_up | input | 1 | Up correction pulse from the phase detector |
| pfd_dn | input | 1 | Down correction pulse from the phase detector |
| cfg_dec_step | input | STEP_W (3) | Down step; 0 selects the default |
| cfg_set_thr | input | CNT_W (8) | Count at or above which lock is declared |
| cfg_clr_thr | input | CNT_W (8) | Count at or below which lock is dropped |
| locked | output | 1 | High when the loop is judged locked |
| lock_n | output | 1 | Low when the loop is judged locked |

## Verification
Clock by clock, the embedded properties check the counter arithmetic: the step-sized fall, the clamp at zero, the single-step rise and the hold at full scale. They also check that every rise of the flag coincides with a count at or above the upper threshold, every fall with a count at or below the lower one, and that the flag stays steady inside the band. The bench alone can show that the default step is actually chosen when the field is 0. It also shows the end-to-end timing of acquisition versus loss under realistic pulse patterns: sparse overlaps that keep lock, dense overlaps that lose it, and the set-wins case with crossed thresholds. All of these are visible only at the flag and its complement.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;

   typedef enum logic {
      LD_UNLOCKED = 1'b0,
      LD_LOCKED   = 1'b1
   } ld_state_e;

   localparam int unsigned LD_DEFAULT_STEP = 3;

endpackage

// File: rtl/lockdet_coinc.sv
module lockdet_coinc #(
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic up_i,
   input  logic dn_i,
   output logic coinc_o
);

   if (SYNC_STAGES > 3) begin : g_bad_sync
      $error("lockdet_coinc: SYNC_STAGES must be 0..3");
   end

   if (SYNC_STAGES == 0) begin : g_direct
      assign coinc_o = up_i & dn_i;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] up_sr;
      logic [SYNC_STAGES-1:0] dn_sr;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            up_sr <= '0;
            dn_sr <= '0;
         end else begin
            up_sr[0] <= up_i;
            dn_sr[0] <= dn_i;
            for (int k = 1; k < int'(SYNC_STAGES); k++) begin
               up_sr[k] <= up_sr[k-1];
               dn_sr[k] <= dn_sr[k-1];
            end
         end
      end

      assign coinc_o = up_sr[SYNC_STAGES-1] & dn_sr[SYNC_STAGES-1];
   end

endmodule

// File: rtl/lockdet_integ.sv
module lockdet_integ #(
   parameter int unsigned CNT_W        = 8,
   parameter int unsigned STEP_W       = 3,
   parameter int unsigned DEF_STEP     = lockdet_pkg::LD_DEFAULT_STEP,
   parameter bit          PROG_STEP    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              coinc_i,
   input  logic [STEP_W-1:0] step_i,
   output logic [CNT_W-1:0]  cnt_nxt_o,
   output logic [CNT_W-1:0]  cnt_q_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
   localparam logic [CNT_W-1:0] DEF_EXT = CNT_W'(DEF_STEP);

   if (CNT_W <= STEP_W) begin : g_bad_w
      $error("lockdet_integ: CNT_W must exceed STEP_W");
   end
   if (DEF_STEP == 0 || DEF_STEP >= (1 << STEP_W)) begin : g_bad_def
      $error("lockdet_integ: DEF_STEP must be 1..2**STEP_W-1");
   end

   logic [CNT_W-1:0] step_eff;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_nxt;

   if (PROG_STEP) begin : g_prog
      always_comb begin
         if (step_i == '0) step_eff = DEF_EXT;
         else              step_eff = {{(CNT_W-STEP_W){1'b0}}, step_i};
      end
   end else begin : g_fixed
      logic unused_step;
      assign unused_step = ^step_i;
      assign step_eff    = DEF_EXT;
   end

   always_comb begin
      if (coinc_i) begin
         if (cnt_q >= step_eff) cnt_nxt = cnt_q - step_eff;
         else                   cnt_nxt = '0;
      end else begin
         if (cnt_q == CNT_MAX)  cnt_nxt = CNT_MAX;
         else                   cnt_nxt = cnt_q + CNT_ONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_nxt;
   end

   assign cnt_nxt_o = cnt_nxt;
   assign cnt_q_o   = cnt_q;

   AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (coinc_i && cnt_q >= step_eff) |=> (cnt_q == $past(cnt_q) - $past(step_eff)))
      else $error("step down wrong"); // R2

   AST_FLOOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (coinc_i && cnt_q < step_eff) |=> (cnt_q == '0))
      else $error("floor wrong"); // R2

   AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (!coinc_i && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + CNT_ONE))
      else $error("step up wrong"); // R3

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!coinc_i && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX))
      else $error("counter wrapped"); // R3

endmodule

// File: rtl/lockdet_hyst.sv
module lockdet_hyst #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt_nxt_i,
   input  logic [CNT_W-1:0] cnt_q_i,
   input  logic [CNT_W-1:0] set_thr_i,
   input  logic [CNT_W-1:0] clr_thr_i,
   output logic             locked_o
);
   import lockdet_pkg::*;

   ld_state_e st_q;
   ld_state_e st_nxt;

   always_comb begin
      st_nxt = st_q;
      if (cnt_nxt_i >= set_thr_i)      st_nxt = LD_LOCKED;
      else if (cnt_nxt_i <= clr_thr_i) st_nxt = LD_UNLOCKED;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= LD_UNLOCKED;
      else        st_q <= st_nxt;
   end

   assign locked_o = (st_q == LD_LOCKED);

   AST_SET_AT_THR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked_o) |-> (cnt_q_i >= $past(set_thr_i)))
      else $error("lock set below threshold"); // R5

   AST_CLR_AT_THR: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(locked_o) |-> (cnt_q_i <= $past(clr_thr_i) && cnt_q_i < $past(set_thr_i)))
      else $error("lock cleared above threshold"); // R6

   AST_HOLD_IN_BAND: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_nxt_i > clr_thr_i && cnt_nxt_i < set_thr_i) |=> $stable(locked_o))
      else $error("flag moved inside band"); // R6

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_nxt_i >= set_thr_i) |=> locked_o)
      else $error("set did not win"); // R7

endmodule

// File: rtl/pfd_lock_monitor.sv
module pfd_lock_monitor #(
   parameter int unsigned CNT_W       = 8,
   parameter int unsigned STEP_W      = 3,
   parameter int unsigned DEF_STEP    = lockdet_pkg::LD_DEFAULT_STEP,
   parameter bit          PROG_STEP   = 1'b1,
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pfd_up,
   input  logic              pfd_dn,
   input  logic [STEP_W-1:0] cfg_dec_step,
   input  logic [CNT_W-1:0]  cfg_set_thr,
   input  logic [CNT_W-1:0]  cfg_clr_thr,
   output logic              locked,
   output logic              lock_n
);

   if (CNT_W < 2 || CNT_W > 24) begin : g_bad_cnt
      $error("pfd_lock_monitor: CNT_W must be 2..24");
   end

   logic             coinc;
   logic [CNT_W-1:0] cnt_nxt;
   logic [CNT_W-1:0] cnt_q;
   logic             flag;

   lockdet_coinc #(
      .SYNC_STAGES (SYNC_STAGES)
   ) u_coinc (
      .clk     (clk),
      .rst_n   (rst_n),
      .up_i    (pfd_up),
      .dn_i    (pfd_dn),
      .coinc_o (coinc)
   );

   lockdet_integ #(
      .CNT_W     (CNT_W),
      .STEP_W    (STEP_W),
      .DEF_STEP  (DEF_STEP),
      .PROG_STEP (PROG_STEP)
   ) u_integ (
      .clk       (clk),
      .rst_n     (rst_n),
      .coinc_i   (coinc),
      .step_i    (cfg_dec_step),
      .cnt_nxt_o (cnt_nxt),
      .cnt_q_o   (cnt_q)
   );

   lockdet_hyst #(
      .CNT_W (CNT_W)
   ) u_hyst (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt_nxt_i (cnt_nxt),
      .cnt_q_i   (cnt_q),
      .set_thr_i (cfg_set_thr),
      .clr_thr_i (cfg_clr_thr),
      .locked_o  (flag)
   );

   assign locked = flag;
   assign lock_n = ~flag;

   AST_UNLOCKED_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0) |-> (!locked || cfg_set_thr == '0 || $past(cfg_set_thr) == '0 || $past(cnt_q) != '0 || $past(locked)))
      else $error("locked at zero count"); // R1

endmodule

// File: tb/pfd_lock_monitor_tb_top.sv
module pfd_lock_monitor_tb_top;

   localparam int CNT_W  = 8;
   localparam int STEP_W = 3;
   localparam int CMAX   = (1 << CNT_W) - 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              pfd_up = 1'b0;
   logic              pfd_dn = 1'b0;
   logic [STEP_W-1:0] cfg_dec_step = '0;
   logic [CNT_W-1:0]  cfg_set_thr = 8'd40;
   logic [CNT_W-1:0]  cfg_clr_thr = 8'd10;
   logic              locked;
   logic              lock_n;

   int vecs  = 0;
   int fails = 0;
   int m_cnt = 0;
   int m_lock = 0;
   int cyc_no = 0;
   logic [15:0] lfsr = 16'hACE1;

   always #2 clk = ~clk;

   pfd_lock_monitor dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .pfd_up       (pfd_up),
      .pfd_dn       (pfd_dn),
      .cfg_dec_step (cfg_dec_step),
      .cfg_set_thr  (cfg_set_thr),
      .cfg_clr_thr  (cfg_clr_thr),
      .locked       (locked),
      .lock_n       (lock_n)
   );

   task automatic compare(input string tag);
      vecs++;
      if (locked !== m_lock[0]) begin
         fails++;
         $display("FAIL %s cycle %0d: locked=%0b expected %0b", tag, cyc_no, locked, m_lock[0]);
      end
      vecs++;
      if (lock_n !== ~m_lock[0]) begin
         fails++;
         $display("FAIL R8 cycle %0d: lock_n=%0b expected %0b", cyc_no, lock_n, ~m_lock[0]);
      end
   endtask

   // behavioural reference: one clock of the integrator and flag
   task automatic cyc(input logic u, input logic d, input string tag);
      int s;
      pfd_up = u;
      pfd_dn = d;
      @(posedge clk);
      s = (cfg_dec_step == 0) ? 3 : int'(cfg_dec_step);
      if (u && d) m_cnt = (m_cnt >= s) ? m_cnt - s : 0;
      else        m_cnt = (m_cnt == CMAX) ? CMAX : m_cnt + 1;
      if (m_cnt >= int'(cfg_set_thr))      m_lock = 1;
      else if (m_cnt <= int'(cfg_clr_thr)) m_lock = 0;
      cyc_no++;
      @(negedge clk);
      compare(tag);
   endtask

   task automatic run(input int n, input logic u, input logic d, input string tag);
      for (int i = 0; i < n; i++) cyc(u, d, tag);
   endtask

   initial begin
      #(200000 * 4);
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
   end

   initial begin
      // R1: state during and right after reset
      repeat (3) @(negedge clk);
      compare("R1");
      rst_n = 1'b1;
      compare("R1");

      // R3 R5: acquisition without any overlap, default step
      run(45, 1'b0, 1'b0, "R5");
      // R9: single-sided pulses count as no overlap
      for (int i = 0; i < 10; i++) begin
         cyc(1'b1, 1'b0, "R9");
         cyc(1'b0, 1'b1, "R9");
      end
      // R6: one overlap in four cycles keeps the count steady, flag holds
      for (int i = 0; i < 10; i++) begin
         cyc(1'b1, 1'b1, "R6");
         run(3, 1'b0, 1'b0, "R6");
      end
      // R2 R6: dense overlap drops lock, then floor at zero
      run(30, 1'b1, 1'b1, "R6");
      run(10, 1'b1, 1'b1, "R2");
      // R4: default step selected by field 0, then explicit step 7
      run(20, 1'b0, 1'b0, "R4");
      run(4, 1'b1, 1'b1, "R4");
      cfg_dec_step = 3'd7;
      run(45, 1'b0, 1'b0, "R4");
      run(8, 1'b1, 1'b1, "R4");
      cfg_dec_step = 3'd1;
      run(50, 1'b0, 1'b0, "R4");
      run(45, 1'b1, 1'b1, "R4");
      cfg_dec_step = 3'd0;
      // R3: saturation at full scale, then a long descent
      run(300, 1'b0, 1'b0, "R3");
      run(90, 1'b1, 1'b1, "R3");
      // R6: band between thresholds with a wider gap
      cfg_set_thr = 8'd100;
      cfg_clr_thr = 8'd60;
      run(110, 1'b0, 1'b0, "R6");
      run(12, 1'b1, 1'b1, "R6");
      run(10, 1'b0, 1'b0, "R6");
      run(20, 1'b1, 1'b1, "R6");
      // R7: crossed thresholds, set wins
      cfg_set_thr = 8'd20;
      cfg_clr_thr = 8'd30;
      run(40, 1'b0, 1'b0, "R7");
      run(20, 1'b1, 1'b1, "R7");
      run(30, 1'b0, 1'b0, "R7");
      // R2 R3 R5 R6: pseudo-random pulse patterns
      cfg_set_thr = 8'd50;
      cfg_clr_thr = 8'd15;
      for (int i = 0; i < 600; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         cyc(lfsr[0] & lfsr[3], lfsr[0] & (lfsr[5] | lfsr[7]), "R2");
      end
      // R1: reset mid-run returns to unlocked
      run(60, 1'b0, 1'b0, "R5");
      @(negedge clk);
      rst_n = 1'b0;
      m_cnt = 0;
      m_lock = 0;
      @(negedge clk);
      compare("R1");
      rst_n = 1'b1;
      run(55, 1'b0, 1'b0, "R1");

      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
   end

endmodule